// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a clocked model of the command register that sits in front of a byte-wide parallel NOR flash array. On every clock where the write strobe is high, it samples the address and data buses. It follows the unlock handshakes and command codes that software writes. When a sequence is complete, it raises a single-cycle start request toward the embedded algorithm engine. The requests cover program, chip erase, sector erase, erase suspend, erase resume, identifier read and reset.

The block also reports the current operating mode. For a program it latches the target address and data byte. For an erase it publishes an 8-bit mask of the sectors to be erased, with protected sectors already removed. The embedded engine reports completion through `op_done`, which returns a busy device to array reads.

Sector erase gathers several sector addresses into one operation. Each accepted sector write restarts a load window whose length in idle cycles is set by `load_window`. When the window runs out, the erase is committed. Any write that does not fit the expected sequence drops the sequence and returns to array-read mode.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read), every start output is low, and `erase_mask`, `prog_addr` and `prog_data` are all zero.
- R2: An unlock is AAh written at command address 555h followed by 55h at 2AAh. Only address bits 10..0 are compared. Bits 18..11 have no effect on command decoding. An unlock followed by 90h at 555h raises `start_id` and sets `mode` to 1 (identifier read).
- R3: An unlock followed by A0h at 555h arms a program. The next write is always taken as the target, even if its data is F0h: it raises `start_prog`, loads `prog_addr`/`prog_data` from that write and sets `mode` to 2 (busy).
- R4: An unlock, 80h at 555h, a second unlock and 10h at 555h raise `start_chip_erase`, set `erase_mask` to the inverse of `prot_mask` and set `mode` to 2.
- R5: The same erase prefix ending in 30h selects the sector given by address bits 18..16, which maps to bit n of the mask. Further 30h writes add sectors and reload the window. With window value W, the erase commits W+1 clocks after the last sector write if no other write arrives. The commit raises `start_sector_erase`, sets `erase_mask` to the collected sectors with protected ones removed, and sets `mode` to 2. While the window is open, `mode` is unchanged.
- R6: If protection removes every selected sector of a chip or sector erase, no start is raised, `erase_mask` keeps its old value and `mode` returns to 0.
- R7: A write that does not match the expected next step aborts the sequence. No start is raised and `mode` becomes 0. A non-30h write during the sector window discards the collected sectors, leaving `erase_mask` unchanged.
- R8: In read or identifier mode, or part way through a sequence, a write of F0h at any address raises `start_reset` and sets `mode` to 0.
- R9: While busy, all writes are ignored except B0h during a sector erase. B0h raises `start_suspend` and sets `mode` to 3 (suspended). B0h during a chip erase is ignored. `op_done` while busy sets `mode` to 0.
- R10: While suspended, only a 30h write has an effect: it raises `start_resume` and sets `mode` to 2. Other writes, including F0h, and `op_done` leave `mode` at 3.
- R11: Each start output is a registered single-cycle pulse. At most one is high in any cycle. It appears on the clock edge that samples the completing write, or the edge that ends the sector window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per high cycle |
| wr_addr | input | 19 | Write address |
| wr_data | input | 8 | Write data |
| op_done | input | 1 | Embedded operation finished |
| prot_mask | input | 8 | Per-sector protection, bit n protects sector n |
| load_window | input | 8 | Sector load window length in idle cycles |
| mode | output | 2 | 0 read, 1 identifier, 2 busy, 3 suspended |
| start_prog | output | 1 | Program start pulse |
| start_chip_erase | output | 1 | Chip erase start pulse |
| start_sector_erase | output | 1 | Sector erase start pulse |
| start_suspend | output | 1 | Erase suspend pulse |
| start_resume | output | 1 | Erase resume pulse |
| start_id | output | 1 | Identifier read pulse |
| start_reset | output | 1 | Reset pulse |
| prog_addr | output | 19 | Latched program address |
| prog_data | output | 8 | Latched program data |
| erase_mask | output | 8 | Sectors to erase after protection |

## Verification
Every start pulse, mode change and program latch is registered on the same rising edge that samples the completing write. The bench drives each write for one cycle from a falling edge and compares the outputs at the next falling edge, so a pulse is seen in the one cycle it is valid. A sector erase commits W+1 edges after the last sector write. The bench therefore counts exactly W idle edges and confirms silence, then advances one more edge and expects the pulse. For aborted and fully protected erases, it watches every cycle of a span longer than the window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    // Command data codes
    localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
    localparam logic [7:0] CMD_PROG     = 8'hA0;
    localparam logic [7:0] CMD_ERASE    = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_SECT     = 8'h30;
    localparam logic [7:0] CMD_SUSP     = 8'hB0;
    localparam logic [7:0] CMD_ID       = 8'h90;
    localparam logic [7:0] CMD_RST      = 8'hF0;

    // Command address compare on the low bits only
    localparam int                CMD_AW = 11;
    localparam logic [CMD_AW-1:0] ADR_A  = 11'h555;
    localparam logic [CMD_AW-1:0] ADR_B  = 11'h2AA;

    typedef enum logic [1:0] {
        MODE_READ = 2'd0,
        MODE_ID   = 2'd1,
        MODE_BUSY = 2'd2,
        MODE_SUSP = 2'd3
    } mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PGM,
        SQ_ERA1,
        SQ_ERA2,
        SQ_ERA3,
        SQ_SLOAD
    } seq_e;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_PROG,
        EV_CHIP,
        EV_SFIRST,
        EV_SADD,
        EV_SUSP,
        EV_RESUME,
        EV_ID,
        EV_RESET,
        EV_ABORT
    } ev_e;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
        logic susp;
        logic resume;
        logic id;
        logic rst;
    } pulse_t;

    function automatic logic cyc_match(
        input logic [CMD_AW-1:0] a,
        input logic [7:0]        d,
        input logic [CMD_AW-1:0] exp_a,
        input logic [7:0]        exp_d
    );
        return (a == exp_a) && (d == exp_d);
    endfunction

endpackage

// File: rtl/fcd_seq.sv
module fcd_seq
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  mode_e             mode,
    input  logic              busy_sect,
    input  logic              win_expire,
    output ev_e               ev
);

    seq_e st_q;
    seq_e st_d;

    always_comb begin
        ev   = EV_NONE;
        st_d = st_q;
        if (wr_en) begin
            case (mode)
                MODE_BUSY: begin
                    if (busy_sect && (cmd_data == CMD_SUSP)) begin
                        ev = EV_SUSP;
                    end
                end
                MODE_SUSP: begin
                    if (cmd_data == CMD_SECT) begin
                        ev = EV_RESUME;
                    end
                end
                default: begin
                    if (st_q == SQ_PGM) begin
                        ev   = EV_PROG;
                        st_d = SQ_IDLE;
                    end else if (cmd_data == CMD_RST) begin
                        ev   = EV_RESET;
                        st_d = SQ_IDLE;
                    end else begin
                        ev   = EV_ABORT;
                        st_d = SQ_IDLE;
                        case (st_q)
                            SQ_IDLE, SQ_ERA1: begin
                                if (cyc_match(cmd_addr, cmd_data, ADR_A, CMD_UNLOCK_A)) begin
                                    ev   = EV_NONE;
                                    st_d = (st_q == SQ_IDLE) ? SQ_UNL1 : SQ_ERA2;
                                end
                            end
                            SQ_UNL1, SQ_ERA2: begin
                                if (cyc_match(cmd_addr, cmd_data, ADR_B, CMD_UNLOCK_B)) begin
                                    ev   = EV_NONE;
                                    st_d = (st_q == SQ_UNL1) ? SQ_UNL2 : SQ_ERA3;
                                end
                            end
                            SQ_UNL2: begin
                                if (cmd_addr == ADR_A) begin
                                    case (cmd_data)
                                        CMD_PROG: begin
                                            ev   = EV_NONE;
                                            st_d = SQ_PGM;
                                        end
                                        CMD_ERASE: begin
                                            ev   = EV_NONE;
                                            st_d = SQ_ERA1;
                                        end
                                        CMD_ID: begin
                                            ev   = EV_ID;
                                            st_d = SQ_IDLE;
                                        end
                                        default: ;
                                    endcase
                                end
                            end
                            SQ_ERA3: begin
                                if (cyc_match(cmd_addr, cmd_data, ADR_A, CMD_CHIP)) begin
                                    ev   = EV_CHIP;
                                    st_d = SQ_IDLE;
                                end else if (cmd_data == CMD_SECT) begin
                                    ev   = EV_SFIRST;
                                    st_d = SQ_SLOAD;
                                end
                            end
                            SQ_SLOAD: begin
                                if (cmd_data == CMD_SECT) begin
                                    ev   = EV_SADD;
                                    st_d = SQ_SLOAD;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            endcase
        end else if ((st_q == SQ_SLOAD) && win_expire) begin
            st_d = SQ_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fcd_window.sv
module fcd_window
    import flash_cmd_pkg::*;
#(
    parameter  int SECT_BITS = 3,
    parameter  int WIN_W     = 8,
    localparam int NSECT     = 1 << SECT_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SECT_BITS-1:0] sect_idx,
    input  logic [WIN_W-1:0]     window,
    input  ev_e                  ev,
    output logic                 expire,
    output logic [NSECT-1:0]     pend
);

    logic             active_q;
    logic [WIN_W-1:0] cnt_q;
    logic [NSECT-1:0] sel;

    for (genvar g = 0; g < NSECT; g++) begin : g_dec
        assign sel[g] = (sect_idx == SECT_BITS'(g));
    end

    assign expire = active_q && !wr_en && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            pend     <= '0;
        end else begin
            case (ev)
                EV_SFIRST: begin
                    active_q <= 1'b1;
                    cnt_q    <= window;
                    pend     <= sel;
                end
                EV_SADD: begin
                    cnt_q <= window;
                    pend  <= pend | sel;
                end
                EV_ABORT, EV_RESET: begin
                    active_q <= 1'b0;
                    pend     <= '0;
                end
                default: begin
                    if (expire) begin
                        active_q <= 1'b0;
                        pend     <= '0;
                    end else if (active_q && !wr_en && (cnt_q != '0)) begin
                        cnt_q <= cnt_q - WIN_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/fcd_mode.sv
module fcd_mode
    import flash_cmd_pkg::*;
#(
    parameter  int ADDR_W    = 19,
    parameter  int SECT_BITS = 3,
    localparam int NSECT     = 1 << SECT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  ev_e               ev,
    input  logic              expire,
    input  logic [NSECT-1:0]  pend,
    input  logic [NSECT-1:0]  prot_mask,
    input  logic              op_done,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output mode_e             mode,
    output logic              busy_sect,
    output pulse_t            pls,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic [NSECT-1:0]  erase_mask
);

    logic [NSECT-1:0] sect_sel;
    logic [NSECT-1:0] chip_sel;

    assign sect_sel = pend & ~prot_mask;
    assign chip_sel = ~prot_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= MODE_READ;
            busy_sect  <= 1'b0;
            pls        <= '0;
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_mask <= '0;
        end else begin
            pls <= '0;
            if ((mode == MODE_BUSY) && op_done) begin
                mode <= MODE_READ;
            end else if (expire) begin
                if (sect_sel != '0) begin
                    pls.sect   <= 1'b1;
                    erase_mask <= sect_sel;
                    busy_sect  <= 1'b1;
                    mode       <= MODE_BUSY;
                end else begin
                    mode <= MODE_READ;
                end
            end else begin
                case (ev)
                    EV_PROG: begin
                        pls.prog  <= 1'b1;
                        prog_addr <= wr_addr;
                        prog_data <= wr_data;
                        busy_sect <= 1'b0;
                        mode      <= MODE_BUSY;
                    end
                    EV_CHIP: begin
                        if (chip_sel != '0) begin
                            pls.chip   <= 1'b1;
                            erase_mask <= chip_sel;
                            busy_sect  <= 1'b0;
                            mode       <= MODE_BUSY;
                        end else begin
                            mode <= MODE_READ;
                        end
                    end
                    EV_SUSP: begin
                        pls.susp <= 1'b1;
                        mode     <= MODE_SUSP;
                    end
                    EV_RESUME: begin
                        pls.resume <= 1'b1;
                        mode       <= MODE_BUSY;
                    end
                    EV_ID: begin
                        pls.id <= 1'b1;
                        mode   <= MODE_ID;
                    end
                    EV_RESET: begin
                        pls.rst <= 1'b1;
                        mode    <= MODE_READ;
                    end
                    EV_ABORT: begin
                        mode <= MODE_READ;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter  int ADDR_W    = 19,
    parameter  int SECT_BITS = 3,
    parameter  int WIN_W     = 8,
    localparam int NSECT     = 1 << SECT_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              op_done,
    input  logic [NSECT-1:0]  prot_mask,
    input  logic [WIN_W-1:0]  load_window,
    output logic [1:0]        mode,
    output logic              start_prog,
    output logic              start_chip_erase,
    output logic              start_sector_erase,
    output logic              start_suspend,
    output logic              start_resume,
    output logic              start_id,
    output logic              start_reset,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic [NSECT-1:0]  erase_mask
);

    ev_e              ev;
    mode_e            mode_q;
    logic             busy_sect;
    logic             expire;
    logic [NSECT-1:0] pend;
    pulse_t           pls;

    fcd_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .cmd_addr   (wr_addr[CMD_AW-1:0]),
        .cmd_data   (wr_data),
        .mode       (mode_q),
        .busy_sect  (busy_sect),
        .win_expire (expire),
        .ev         (ev)
    );

    fcd_window #(
        .SECT_BITS (SECT_BITS),
        .WIN_W     (WIN_W)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .sect_idx (wr_addr[ADDR_W-1 -: SECT_BITS]),
        .window   (load_window),
        .ev       (ev),
        .expire   (expire),
        .pend     (pend)
    );

    fcd_mode #(
        .ADDR_W    (ADDR_W),
        .SECT_BITS (SECT_BITS)
    ) u_mode (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .expire     (expire),
        .pend       (pend),
        .prot_mask  (prot_mask),
        .op_done    (op_done),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .mode       (mode_q),
        .busy_sect  (busy_sect),
        .pls        (pls),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .erase_mask (erase_mask)
    );

    assign mode               = mode_q;
    assign start_prog         = pls.prog;
    assign start_chip_erase   = pls.chip;
    assign start_sector_erase = pls.sect;
    assign start_suspend      = pls.susp;
    assign start_resume       = pls.resume;
    assign start_id           = pls.id;
    assign start_reset        = pls.rst;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import flash_cmd_pkg::*;
#(
    parameter int NSECT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [NSECT-1:0] prot_mask,
    input logic [1:0]       mode,
    input logic             start_prog,
    input logic             start_chip_erase,
    input logic             start_sector_erase,
    input logic             start_suspend,
    input logic             start_resume,
    input logic             start_id,
    input logic             start_reset,
    input logic [NSECT-1:0] erase_mask
);

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_prog, start_chip_erase, start_sector_erase, start_suspend,
                  start_resume, start_id, start_reset})); // R11

    AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start_prog |=> !start_prog); // R11

    AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (start_prog || start_chip_erase || start_suspend || start_resume || start_id || start_reset)
        |-> $past(wr_en)); // R11

    AST_PROG_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_prog |-> (mode == MODE_BUSY)); // R3

    AST_ERASE_UNPROT: assert property (@(posedge clk) disable iff (rst)
        (start_chip_erase || start_sector_erase)
        |-> (((erase_mask & $past(prot_mask)) == '0) && (erase_mask != '0))); // R6

    AST_SUSP_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
        start_suspend |-> (($past(mode) == MODE_BUSY) && (mode == MODE_SUSP))); // R9

    AST_RESUME_FROM_SUSP: assert property (@(posedge clk) disable iff (rst)
        start_resume |-> (($past(mode) == MODE_SUSP) && (mode == MODE_BUSY))); // R10

    AST_SUSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (($past(mode) == MODE_SUSP) && !start_resume) |-> (mode == MODE_SUSP)); // R10

endmodule

bind flash_cmd_decoder fcd_checker #(.NSECT(NSECT)) u_fcd_checker (
    .clk                (clk),
    .rst                (rst),
    .wr_en              (wr_en),
    .prot_mask          (prot_mask),
    .mode               (mode),
    .start_prog         (start_prog),
    .start_chip_erase   (start_chip_erase),
    .start_sector_erase (start_sector_erase),
    .start_suspend      (start_suspend),
    .start_resume       (start_resume),
    .start_id           (start_id),
    .start_reset        (start_reset),
    .erase_mask         (erase_mask)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        op_done = 1'b0;
    logic [7:0]  prot_mask = '0;
    logic [7:0]  load_window = 8'd3;
    logic [1:0]  mode;
    logic        start_prog, start_chip_erase, start_sector_erase;
    logic        start_suspend, start_resume, start_id, start_reset;
    logic [18:0] prog_addr;
    logic [7:0]  prog_data;
    logic [7:0]  erase_mask;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .op_done (op_done), .prot_mask (prot_mask), .load_window (load_window),
        .mode (mode), .start_prog (start_prog), .start_chip_erase (start_chip_erase),
        .start_sector_erase (start_sector_erase), .start_suspend (start_suspend),
        .start_resume (start_resume), .start_id (start_id), .start_reset (start_reset),
        .prog_addr (prog_addr), .prog_data (prog_data), .erase_mask (erase_mask)
    );

    // pulse order: prog chip sect susp resume id reset
    function automatic logic [6:0] pulses();
        return {start_prog, start_chip_erase, start_sector_erase, start_suspend,
                start_resume, start_id, start_reset};
    endfunction

    typedef struct packed {
        logic        w;
        logic        done;
        logic [18:0] a;
        logic [7:0]  d;
        logic [1:0]  m;
        logic [6:0]  p;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 19'h00555, 8'hAA, 2'd0, 7'h00, 4'd2},  // R2 unlock
        '{1'b1, 1'b0, 19'h002AA, 8'h55, 2'd0, 7'h00, 4'd2},
        '{1'b1, 1'b0, 19'h00555, 8'h90, 2'd1, 7'h02, 4'd2},  // R2 id mode
        '{1'b1, 1'b0, 19'h00123, 8'hF0, 2'd0, 7'h01, 4'd8},  // R8 reset from id
        '{1'b1, 1'b0, 19'h00555, 8'hAA, 2'd0, 7'h00, 4'd3},  // R3 program
        '{1'b1, 1'b0, 19'h002AA, 8'h55, 2'd0, 7'h00, 4'd3},
        '{1'b1, 1'b0, 19'h00555, 8'hA0, 2'd0, 7'h00, 4'd3},
        '{1'b1, 1'b0, 19'h41234, 8'h5A, 2'd2, 7'h40, 4'd3},
        '{1'b1, 1'b0, 19'h00555, 8'hAA, 2'd2, 7'h00, 4'd9},  // R9 busy ignores
        '{1'b0, 1'b1, 19'h00000, 8'h00, 2'd0, 7'h00, 4'd9},  // R9 done
        '{1'b1, 1'b0, 19'h7D555, 8'hAA, 2'd0, 7'h00, 4'd2},  // R2 high bits ignored
        '{1'b1, 1'b0, 19'h1A2AA, 8'h55, 2'd0, 7'h00, 4'd2},
        '{1'b1, 1'b0, 19'h00555, 8'h90, 2'd1, 7'h02, 4'd2},
        '{1'b1, 1'b0, 19'h00555, 8'h00, 2'd0, 7'h00, 4'd7},  // R7 bad write in id
        '{1'b1, 1'b0, 19'h00555, 8'hAA, 2'd0, 7'h00, 4'd7},
        '{1'b1, 1'b0, 19'h002AA, 8'h56, 2'd0, 7'h00, 4'd7},  // R7 wrong data
        '{1'b1, 1'b0, 19'h002AA, 8'h55, 2'd0, 7'h00, 4'd7},
        '{1'b1, 1'b0, 19'h00555, 8'hA0, 2'd0, 7'h00, 4'd7},
        '{1'b1, 1'b0, 19'h00000, 8'h77, 2'd0, 7'h00, 4'd7},  // R7 no program
        '{1'b1, 1'b0, 19'h00555, 8'hAA, 2'd0, 7'h00, 4'd4},  // R4 chip erase
        '{1'b1, 1'b0, 19'h002AA, 8'h55, 2'd0, 7'h00, 4'd4},
        '{1'b1, 1'b0, 19'h00555, 8'h80, 2'd0, 7'h00, 4'd4},
        '{1'b1, 1'b0, 19'h00555, 8'hAA, 2'd0, 7'h00, 4'd4},
        '{1'b1, 1'b0, 19'h002AA, 8'h55, 2'd0, 7'h00, 4'd4},
        '{1'b1, 1'b0, 19'h00555, 8'h10, 2'd2, 7'h20, 4'd4},
        '{1'b1, 1'b0, 19'h00555, 8'hB0, 2'd2, 7'h00, 4'd9},  // R9 no chip suspend
        '{1'b0, 1'b1, 19'h00000, 8'h00, 2'd0, 7'h00, 4'd9},
        '{1'b1, 1'b0, 19'h00555, 8'hAA, 2'd0, 7'h00, 4'd3},  // R3 data F0
        '{1'b1, 1'b0, 19'h002AA, 8'h55, 2'd0, 7'h00, 4'd3},
        '{1'b1, 1'b0, 19'h00555, 8'hA0, 2'd0, 7'h00, 4'd3},
        '{1'b1, 1'b0, 19'h0000F, 8'hF0, 2'd2, 7'h40, 4'd3},
        '{1'b0, 1'b1, 19'h00000, 8'h00, 2'd0, 7'h00, 4'd9}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic unlock();
        wr(19'h00555, 8'hAA);
        wr(19'h002AA, 8'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(19'h00555, 8'h80);
        unlock();
    endtask

    task automatic finish_op();
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    // watch n cycles; returns 1 if a sector erase pulse was seen
    task automatic watch_sect(input int n, output logic seen);
        seen = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (start_sector_erase) seen = 1'b1;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic seen;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", 32'(mode), 32'd0);
        chk("R1 pulses", 32'(pulses()), 32'd0);
        chk("R1 erase_mask", 32'(erase_mask), 32'd0);
        chk("R1 prog_addr", 32'(prog_addr), 32'd0);

        for (int i = 0; i < NV; i++) begin
            wr_en   = VEC[i].w;
            op_done = VEC[i].done;
            wr_addr = VEC[i].a;
            wr_data = VEC[i].d;
            @(negedge clk);
            wr_en   = 1'b0;
            op_done = 1'b0;
            chk($sformatf("R%0d vec %0d mode/pulses", VEC[i].rq, i),
                32'({mode, pulses()}), 32'({VEC[i].m, VEC[i].p}));
        end
        chk("R3 prog_addr", 32'(prog_addr), 32'h0000F);
        chk("R3 prog_data", 32'(prog_data), 32'hF0);
        chk("R4 chip mask", 32'(erase_mask), 32'hFF);

        // R5 multi-sector erase with protection, window 3
        prot_mask   = 8'h04;
        load_window = 8'd3;
        erase_prefix();
        wr(19'h10000, 8'h30);
        idle(1);
        wr(19'h28000, 8'h30);
        wr(19'h60123, 8'h30);
        watch_sect(3, seen);
        chk("R5 no early commit", 32'(seen), 32'd0);
        chk("R5 mode in window", 32'(mode), 32'd0);
        idle(1);
        chk("R5 commit pulse", 32'(start_sector_erase), 32'd1);
        chk("R5 commit mask", 32'(erase_mask), 32'h42);
        chk("R5 busy", 32'(mode), 32'd2);
        idle(1);
        chk("R11 pulse one cycle", 32'(pulses()), 32'd0);

        // R9 / R10 suspend and resume
        wr(19'h12345, 8'hB0);
        chk("R9 suspend", 32'({mode, pulses()}), 32'({2'd3, 7'h08}));
        wr(19'h00555, 8'hAA);
        chk("R10 ignore unlock", 32'({mode, pulses()}), 32'({2'd3, 7'h00}));
        wr(19'h00000, 8'hF0);
        chk("R10 ignore reset", 32'({mode, pulses()}), 32'({2'd3, 7'h00}));
        finish_op();
        chk("R10 ignore done", 32'(mode), 32'd3);
        wr(19'h00000, 8'h30);
        chk("R10 resume", 32'({mode, pulses()}), 32'({2'd2, 7'h04}));
        finish_op();
        chk("R9 done to read", 32'(mode), 32'd0);

        // R7 abort inside window
        prot_mask = 8'h00;
        erase_prefix();
        wr(19'h30000, 8'h30);
        wr(19'h00555, 8'hAA);
        chk("R7 abort mode", 32'({mode, pulses()}), 32'd0);
        watch_sect(6, seen);
        chk("R7 no erase after abort", 32'(seen), 32'd0);
        chk("R7 mask kept", 32'(erase_mask), 32'h42);

        // R6 all selected sectors protected
        prot_mask = 8'h08;
        erase_prefix();
        wr(19'h30000, 8'h30);
        watch_sect(6, seen);
        chk("R6 no sector start", 32'(seen), 32'd0);
        chk("R6 mode read", 32'(mode), 32'd0);
        chk("R6 mask kept", 32'(erase_mask), 32'h42);

        // R5 zero-length window
        prot_mask   = 8'h00;
        load_window = 8'd0;
        erase_prefix();
        wr(19'h50000, 8'h30);
        idle(1);
        chk("R5 window zero pulse", 32'(start_sector_erase), 32'd1);
        chk("R5 window zero mask", 32'(erase_mask), 32'h20);
        finish_op();

        // R5 window reload by later sector write
        load_window = 8'd2;
        erase_prefix();
        wr(19'h00000, 8'h30);
        idle(2);
        wr(19'h70000, 8'h30);
        watch_sect(2, seen);
        chk("R5 reload no early", 32'(seen), 32'd0);
        idle(1);
        chk("R5 reload commit", 32'({start_sector_erase, erase_mask}), 32'({1'b1, 8'h81}));
        finish_op();

        // R4 chip erase with partial protection
        prot_mask = 8'h81;
        erase_prefix();
        wr(19'h00555, 8'h10);
        chk("R4 chip pulse", 32'(start_chip_erase), 32'd1);
        chk("R4 chip mask", 32'(erase_mask), 32'h7E);
        finish_op();

        // R6 chip erase with everything protected
        prot_mask = 8'hFF;
        erase_prefix();
        wr(19'h00555, 8'h10);
        chk("R6 chip none", 32'({mode, pulses()}), 32'd0);
        chk("R6 chip mask kept", 32'(erase_mask), 32'h7E);

        // R8 reset during window
        prot_mask = 8'h00;
        erase_prefix();
        wr(19'h10000, 8'h30);
        wr(19'h00000, 8'hF0);
        chk("R8 reset in window", 32'({mode, pulses()}), 32'({2'd0, 7'h01}));
        watch_sect(5, seen);
        chk("R8 no erase after reset", 32'(seen), 32'd0);

        summary();
        $finish;
    end

endmodule